// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit core's load/store path and a byte-addressable data memory that is one word wide. For each request it takes the byte address, an access size (byte, halfword or word), a signed/unsigned flag, a read/write flag and store data. It produces a word address for the memory, a memory enable, a write enable, per-lane byte enables and store data already placed on the proper lanes. Data returned by the memory is cut out of the word, reordered for the active byte order and sign- or zero-extended before it goes back to the core.

The physical memory layout never changes: lane k of a memory word always holds the byte at word address + k. A mode input chooses how multi-byte values map onto those bytes. In little-endian mode the lowest address holds the least significant byte. In big-endian mode the lowest address holds the most significant byte. Both byte orders can therefore read and write the same memory contents. Accesses that break the natural alignment of their size are refused: the memory sees no enable, and a one-cycle error pulse follows.

The memory is assumed to behave like a synchronous block RAM, returning read data one clock after the address is presented. The unit's response path is timed to match that latency.

Top module: `lsu_align`

## Requirements
- R1: In the cycle of an accepted request, `mem_addr_o` equals `req_addr_i` with bits [1:0] cleared. `mem_en_o` is high. `mem_we_o` equals `req_write_i`. With no request, `mem_en_o` and `mem_we_o` are low.
- R2: Alignment rules depend on the size code. Byte accesses (size code 0) are always aligned. Halfword accesses (code 1) need address bit 0 at 0. Word accesses (code 2) need address bits [1:0] at 00. Code 3 is always refused. A refused request keeps `mem_en_o`, `mem_we_o` and `mem_be_o` at zero, so memory is left untouched. `misalign_o` pulses high for one cycle on the next clock. No load response is produced for it.
- R3: `mem_be_o` is zero except in the cycle of an accepted store. For a store with offset o = addr[1:0], the enabled bits are: bit o for a byte; bits o and o+1 for a halfword; all four bits for a word. The pattern is the same in both byte orders.
- R4: In little-endian mode, a byte store puts `req_wdata_i[7:0]` on all four lanes. A halfword store puts bits [7:0] on its lower-addressed lane and bits [15:8] on the other, repeated on both lane pairs. A word store puts data bits [8k+7:8k] on lane k.
- R5: In big-endian mode, a byte store behaves as in R4. A halfword store puts bits [15:8] on its lower-addressed lane and bits [7:0] on the other, repeated on both lane pairs. A word store puts data bits [31-8k:24-8k] on lane k.
- R6: In little-endian mode, a load assembles its value as follows. A byte load returns lane o. A halfword load returns {lane o+1, lane o}. A word load returns {lane 3, lane 2, lane 1, lane 0}. For example, with bytes 1A, C8, B2, 46 at addresses 0 to 3, a word load from 0 returns 0x46B2C81A.
- R7: In big-endian mode, a load assembles its value as follows. A byte load returns lane o. A halfword load returns {lane o, lane o+1}. A word load returns {lane 0, lane 1, lane 2, lane 3}. With the same four bytes, a word load from 0 returns 0x1AC8B246.
- R8: A signed byte or halfword load copies the top bit of the field into every upper bit of `rsp_data_o`. An unsigned load fills the upper bits with zeros. The flag has no effect on word loads.
- R9: `rsp_valid_o` is high for exactly one cycle, on the clock after each accepted load. `rsp_data_o` holds the result in that cycle. Stores never produce `rsp_valid_o`.
- R10: `big_endian_i` is captured into the active mode only on a clock edge where no request is presented and no load response is due. The captured value applies from the following cycle. A change during a stream of back-to-back requests therefore takes effect only after the stream ends and one more clock passes.
- R11: After reset, `rsp_valid_o` and `misalign_o` are low, and the active mode is little-endian until an idle clock captures `big_endian_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian_i | input | 1 | Byte-order select, 1 = big-endian |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Byte address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed_i | input | 1 | Sign-extend byte and halfword loads |
| req_wdata_i | input | 32 | Store data, right-justified |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Per-lane byte enables, lane k = address + k |
| mem_wdata_o | output | 32 | Lane-steered store data |
| mem_rdata_i | input | 32 | Read data, one clock after the address |
| misalign_o | output | 1 | One-cycle error pulse for a refused request |
| rsp_valid_o | output | 1 | Load result valid |
| rsp_data_o | output | 32 | Extended load result |

## Verification
The memory-side outputs (address, enables and steered store data) are due in the same cycle as the request. The bench samples them on the falling edge of that cycle, after driving the inputs just past the rising edge. Load results and the error pulse are due one clock later. Each scoreboard entry carries the cycle number in which its result must appear. The monitor samples on every falling edge and flags both a missing result in its due cycle and any result that nothing predicted. The mode-capture rule is exercised by flipping the mode input during an unbroken run of loads: the expected values keep the old byte order until two idle clocks have passed.

// File: rtl/lsu_align_pkg.sv
`timescale 1ns/1ps
package lsu_align_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;

endpackage

// File: rtl/lsu_req_decode.sv
`timescale 1ns/1ps
module lsu_req_decode
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  acc_size_e         size_i,
  output logic              ok_o,
  output logic              en_o,
  output logic              we_o,
  output logic [DATA_W/8-1:0] be_o,
  output logic [ADDR_W-1:0] maddr_o
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  logic [OFS_W-1:0] ofs;
  logic [LANES-1:0] mask;
  logic             fits;

  assign ofs = addr_i[OFS_W-1:0];

  always_comb begin
    fits = 1'b0;
    mask = '0;
    case (size_i)
      ACC_BYTE: begin
        fits = 1'b1;
        mask = LANES'(1) << ofs;
      end
      ACC_HALF: begin
        fits = ~ofs[0];
        mask = LANES'(3) << ofs;
      end
      ACC_WORD: begin
        fits = (ofs == '0);
        mask = '1;
      end
      default: begin
        fits = 1'b0;
        mask = '0;
      end
    endcase
  end

  assign ok_o    = fits;
  assign en_o    = valid_i & fits;
  assign we_o    = valid_i & fits & write_i;
  assign be_o    = (valid_i & fits & write_i) ? mask : '0;
  assign maddr_o = {addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

endmodule

// File: rtl/lsu_store_steer.sv
`timescale 1ns/1ps
module lsu_store_steer
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              big_endian_i,
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] lanes_o
);
  localparam int LANES = DATA_W / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int PAIR = k % 2;
    logic [7:0] lane_byte;
    always_comb begin
      case (size_i)
        ACC_BYTE: lane_byte = wdata_i[7:0];
        ACC_HALF: lane_byte = big_endian_i ? wdata_i[8*(1-PAIR) +: 8]
                                           : wdata_i[8*PAIR +: 8];
        default:  lane_byte = big_endian_i ? wdata_i[8*(LANES-1-k) +: 8]
                                           : wdata_i[8*k +: 8];
      endcase
    end
    assign lanes_o[8*k +: 8] = lane_byte;
  end

endmodule

// File: rtl/lsu_load_extract.sv
`timescale 1ns/1ps
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        big_endian_i,
  input  acc_size_e                   size_i,
  input  logic                        signed_i,
  input  logic [$clog2(DATA_W/8)-1:0] ofs_i,
  input  logic [DATA_W-1:0]           rdata_i,
  output logic [DATA_W-1:0]           data_o
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  logic [DATA_W-1:0] reversed;
  logic [OFS_W+2:0]  lo_pos;
  logic [OFS_W+2:0]  hi_pos;
  logic [7:0]        lo_byte;
  logic [7:0]        hi_byte;
  logic [15:0]       half;

  for (genvar k = 0; k < LANES; k++) begin : g_rev
    assign reversed[8*k +: 8] = rdata_i[8*(LANES-1-k) +: 8];
  end

  assign lo_pos  = {ofs_i, 3'b000};
  assign hi_pos  = {ofs_i | OFS_W'(1), 3'b000};
  assign lo_byte = rdata_i[lo_pos +: 8];
  assign hi_byte = rdata_i[hi_pos +: 8];
  assign half    = big_endian_i ? {lo_byte, hi_byte} : {hi_byte, lo_byte};

  always_comb begin
    case (size_i)
      ACC_BYTE: data_o = {{(DATA_W-8){signed_i & lo_byte[7]}}, lo_byte};
      ACC_HALF: data_o = {{(DATA_W-16){signed_i & half[15]}}, half};
      default:  data_o = big_endian_i ? reversed : rdata_i;
    endcase
  end

endmodule

// File: rtl/lsu_align.sv
`timescale 1ns/1ps
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_endian_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_signed_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              misalign_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  acc_size_e        req_size;
  logic             req_ok;
  logic             load_go;

  logic             mode_q;
  logic             pend_q;
  logic             misalign_q;
  acc_size_e        psize_q;
  logic             psigned_q;
  logic [OFS_W-1:0] pofs_q;

  assign req_size = acc_size_e'(req_size_i);

  lsu_req_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .size_i  (req_size),
    .ok_o    (req_ok),
    .en_o    (mem_en_o),
    .we_o    (mem_we_o),
    .be_o    (mem_be_o),
    .maddr_o (mem_addr_o)
  );

  lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
    .big_endian_i (mode_q),
    .size_i       (req_size),
    .wdata_i      (req_wdata_i),
    .lanes_o      (mem_wdata_o)
  );

  assign load_go = req_valid_i & req_ok & ~req_write_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= 1'b0;
      pend_q     <= 1'b0;
      misalign_q <= 1'b0;
      psize_q    <= ACC_BYTE;
      psigned_q  <= 1'b0;
      pofs_q     <= '0;
    end else begin
      pend_q     <= load_go;
      misalign_q <= req_valid_i & ~req_ok;
      if (load_go) begin
        psize_q   <= req_size;
        psigned_q <= req_signed_i;
        pofs_q    <= req_addr_i[OFS_W-1:0];
      end
      if (!req_valid_i && !pend_q) begin
        mode_q <= big_endian_i;
      end
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
    .big_endian_i (mode_q),
    .size_i       (psize_q),
    .signed_i     (psigned_q),
    .ofs_i        (pofs_q),
    .rdata_i      (mem_rdata_i),
    .data_o       (rsp_data_o)
  );

  assign rsp_valid_o = pend_q;
  assign misalign_o  = misalign_q;

endmodule

// File: rtl/lsu_align_chk.sv
`timescale 1ns/1ps
module lsu_align_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        req_size_i,
  input logic              req_signed_i,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W/8-1:0] mem_be_o,
  input logic              misalign_o,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              mode_q
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    mem_en_o |-> (mem_addr_o[OFS_W-1:0] == '0));

  assert_write_needs_en_R1: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_en_o);

  assert_refused_blocked_R2: assert property (@(posedge clk) disable iff (rst)
    misalign_o |-> ($past(mem_be_o) == '0 && !$past(mem_en_o)));

  assert_no_rsp_on_error_R2: assert property (@(posedge clk) disable iff (rst)
    misalign_o |-> !rsp_valid_o);

  assert_be_shape_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                  $countones(mem_be_o) == LANES));

  assert_be_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_o |-> (mem_be_o == '0));

  assert_zero_ext_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && $past(req_size_i == 2'd0 && !req_signed_i))
      |-> (rsp_data_o[DATA_W-1:8] == '0));

  assert_rsp_after_load_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> $past(mem_en_o && !mem_we_o));

  assert_load_gets_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_en_o && !mem_we_o) |=> rsp_valid_o);

  assert_mode_held_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> $stable(mode_q));

endmodule

bind lsu_align lsu_align_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_size_i   (req_size_i),
  .req_signed_i (req_signed_i),
  .mem_en_o     (mem_en_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_be_o     (mem_be_o),
  .misalign_o   (misalign_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_data_o   (rsp_data_o),
  .mode_q       (mode_q)
);

// File: tb/lsu_align_test.sv
`timescale 1ns/1ps
module lsu_align_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_signed_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        mem_en_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        misalign_o, rsp_valid_o;
  logic [31:0] rsp_data_o;

  always #10 clk = ~clk;

  lsu_align uut (
    .clk(clk), .rst(rst), .big_endian_i(big_endian_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_size_i(req_size_i),
    .req_signed_i(req_signed_i), .req_wdata_i(req_wdata_i),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .misalign_o(misalign_o), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o)
  );

  logic [7:0] ram [0:67];
  logic [7:0] model_mem [0:67];
  int  cyc = 0;
  int  n_tests = 0;
  int  n_fail = 0;
  bit  bmode = 1'b0;
  bit  finished = 1'b0;

  typedef struct {
    bit          err;
    logic [31:0] data;
    int          due;
    string       tag;
  } exp_t;
  exp_t exp_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (mem_we_o) begin
      for (int k = 0; k < 4; k++)
        if (mem_be_o[k]) ram[int'(mem_addr_o[5:0]) + k] <= mem_wdata_o[8*k +: 8];
    end
    if (mem_en_o && !mem_we_o) begin
      mem_rdata_i <= {ram[int'(mem_addr_o[5:0]) + 3], ram[int'(mem_addr_o[5:0]) + 2],
                      ram[int'(mem_addr_o[5:0]) + 1], ram[int'(mem_addr_o[5:0])]};
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, expv);
    end
  endtask

  function automatic bit is_aligned(input int a, input int sz);
    if (sz == 0) return 1'b1;
    if (sz == 1) return (a % 2) == 0;
    if (sz == 2) return (a % 4) == 0;
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_load(input int a, input int sz, input bit sgn,
                                             input bit be);
    logic [31:0] v;
    logic [15:0] h;
    if (sz == 0) begin
      v = {{24{sgn & model_mem[a][7]}}, model_mem[a]};
    end else if (sz == 1) begin
      h = be ? {model_mem[a], model_mem[a+1]} : {model_mem[a+1], model_mem[a]};
      v = {{16{sgn & h[15]}}, h};
    end else begin
      v = be ? {model_mem[a], model_mem[a+1], model_mem[a+2], model_mem[a+3]}
             : {model_mem[a+3], model_mem[a+2], model_mem[a+1], model_mem[a]};
    end
    return v;
  endfunction

  // Drives one request in the cycle after the next rising edge and checks the
  // memory-side outputs on the falling edge of that same cycle.
  task automatic issue(input bit wr, input int a, input int sz, input bit sgn,
                       input logic [31:0] wd, input string tag);
    bit          ok;
    logic [3:0]  be_exp;
    logic [7:0]  lane_exp [4];
    exp_t        item;
    @(posedge clk);
    #1;
    req_valid_i  = 1'b1;
    req_write_i  = wr;
    req_addr_i   = a;
    req_size_i   = sz[1:0];
    req_signed_i = sgn;
    req_wdata_i  = wd;
    ok = is_aligned(a, sz);
    item.due = cyc + 1;
    item.tag = tag;
    if (!ok) begin
      item.err = 1'b1;
      item.data = '0;
      exp_q.push_back(item);
    end else if (!wr) begin
      item.err = 1'b0;
      item.data = model_load(a, sz, sgn, bmode);
      exp_q.push_back(item);
    end
    be_exp = '0;
    for (int k = 0; k < 4; k++) lane_exp[k] = 8'h00;
    if (ok && wr) begin
      if (sz == 0) begin
        be_exp = 4'b0001 << (a % 4);
        for (int k = 0; k < 4; k++) lane_exp[k] = wd[7:0];
      end else if (sz == 1) begin
        be_exp = 4'b0011 << (a % 4);
        lane_exp[a % 4]     = bmode ? wd[15:8] : wd[7:0];
        lane_exp[a % 4 + 1] = bmode ? wd[7:0]  : wd[15:8];
      end else begin
        be_exp = 4'b1111;
        for (int k = 0; k < 4; k++) lane_exp[k] = bmode ? wd[8*(3-k) +: 8] : wd[8*k +: 8];
      end
    end
    @(negedge clk);
    chk(mem_en_o == ok, ok ? "R1" : "R2", {31'd0, mem_en_o}, {31'd0, ok},
        {tag, " mem_en"});
    chk(mem_we_o == (ok & wr), ok ? "R1" : "R2", {31'd0, mem_we_o}, {31'd0, ok & wr},
        {tag, " mem_we"});
    chk(mem_be_o == be_exp, ok ? "R3" : "R2", {28'd0, mem_be_o}, {28'd0, be_exp},
        {tag, " byte enables"});
    if (ok) begin
      chk(mem_addr_o == (a & ~32'd3), "R1", mem_addr_o, a & ~32'd3, {tag, " address"});
    end
    if (ok && wr) begin
      for (int k = 0; k < 4; k++) begin
        if (be_exp[k] || sz == 0) begin
          chk(mem_wdata_o[8*k +: 8] == lane_exp[k], bmode ? "R5" : "R4",
              {24'd0, mem_wdata_o[8*k +: 8]}, {24'd0, lane_exp[k]}, {tag, " lane data"});
        end
        if (be_exp[k]) model_mem[int'(mem_addr_o[5:0]) + k] = lane_exp[k];
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      req_valid_i = 1'b0;
      req_write_i = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t it;
        it = exp_q.pop_front();
        if (it.err) begin
          chk(misalign_o == 1'b1 && rsp_valid_o == 1'b0, "R2",
              {30'd0, misalign_o, rsp_valid_o}, 32'd2, {it.tag, " error pulse"});
        end else begin
          chk(rsp_valid_o == 1'b1 && misalign_o == 1'b0, "R9",
              {30'd0, misalign_o, rsp_valid_o}, 32'd1, {it.tag, " response valid"});
          chk(rsp_data_o == it.data, it.tag, rsp_data_o, it.data, "load data");
        end
      end else if (rsp_valid_o || misalign_o) begin
        chk(1'b0, "R9", {30'd0, misalign_o, rsp_valid_o}, 32'd0, "unexpected output");
      end
    end
  end

  initial begin
    for (int i = 0; i < 68; i++) begin
      ram[i] = 8'((i * 37 + 5) & 8'hFF);
      model_mem[i] = ram[i];
    end
    ram[0] = 8'h1A; ram[1] = 8'hC8; ram[2] = 8'hB2; ram[3] = 8'h46;
    for (int i = 0; i < 4; i++) model_mem[i] = ram[i];

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid_o == 1'b0 && misalign_o == 1'b0 && mem_en_o == 1'b0, "R11",
        {29'd0, mem_en_o, misalign_o, rsp_valid_o}, 32'd0, "reset state");
    idle(2);

    // Little-endian loads (mode from reset)
    issue(0, 0, 2, 0, 0, "R6");
    issue(0, 0, 1, 1, 0, "R8");
    issue(0, 2, 1, 0, 0, "R6");
    issue(0, 1, 0, 1, 0, "R8");
    issue(0, 1, 0, 0, 0, "R8");
    issue(0, 3, 0, 0, 0, "R6");
    issue(0, 4, 2, 1, 0, "R8");
    // Refused accesses
    issue(0, 1, 1, 0, 0, "R2");
    issue(0, 2, 2, 0, 0, "R2");
    issue(0, 4, 3, 0, 0, "R2");
    issue(1, 5, 2, 0, 32'hDEADBEEF, "R2");
    issue(1, 7, 1, 0, 32'h0000ABCD, "R2");
    issue(0, 4, 2, 0, 0, "R2");
    // Little-endian stores, back-to-back with loads
    issue(1, 9, 0, 0, 32'h000000E7, "R4");
    issue(1, 10, 1, 0, 32'h00009A5C, "R4");
    issue(1, 12, 2, 0, 32'h13579BDF, "R4");
    issue(0, 8, 2, 0, 0, "R6");
    issue(0, 12, 2, 0, 0, "R6");
    issue(0, 10, 1, 1, 0, "R8");
    idle(2);

    // Mode change during an unbroken run: old order must hold
    issue(0, 0, 2, 0, 0, "R10");
    big_endian_i = 1'b1;
    issue(0, 0, 1, 0, 0, "R10");
    issue(0, 12, 2, 0, 0, "R10");
    idle(3);
    bmode = 1'b1;

    // Big-endian loads
    issue(0, 0, 2, 0, 0, "R7");
    issue(0, 0, 1, 0, 0, "R7");
    issue(0, 2, 1, 1, 0, "R8");
    issue(0, 1, 0, 1, 0, "R7");
    issue(0, 12, 2, 0, 0, "R7");
    // Big-endian stores and read-back
    issue(1, 21, 0, 0, 32'h00000081, "R5");
    issue(1, 22, 1, 0, 32'h0000C3A4, "R5");
    issue(1, 24, 2, 0, 32'hA1B2C3D4, "R5");
    issue(0, 20, 2, 0, 0, "R7");
    issue(0, 24, 2, 0, 0, "R7");
    issue(0, 22, 1, 1, 0, "R8");
    issue(1, 26, 1, 0, 32'h00001234, "R3");
    issue(0, 24, 2, 0, 0, "R7");
    idle(2);

    // Back to little-endian, read what big-endian wrote
    big_endian_i = 1'b0;
    idle(3);
    bmode = 1'b0;
    issue(0, 24, 2, 0, 0, "R6");
    issue(0, 22, 1, 0, 0, "R6");
    issue(0, 20, 2, 0, 0, "R6");
    idle(4);

    chk(exp_q.size() == 0, "R9", exp_q.size(), 0, "pending scoreboard items");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule